// File: doc/BRIEF.md
# NAND Flash Asynchronous Bus Sequencer

This block turns single-cycle host requests into timed accesses on an 8-bit asynchronous NAND flash bus. Each host request is one bus cycle, either a write or a read. Two host address bits choose the kind of cycle. One bit marks a command cycle, which drives the command latch enable. The other bit marks an address cycle, which drives the address latch enable. With neither bit set, the request is a plain data cycle. Each access runs through a setup phase, a strobe phase and a hold phase. The length of each phase comes from one packed 32-bit timing word, with separate fields for reads and writes. A turnaround gap is placed between accesses only when the transfer direction changes.

The block also tracks the flash ready/busy line. It offers a wait-and-status operation: the block waits for the device to report ready, then issues the status command, then returns one data byte. The host's chip-select input drives the flash chip enable. The same input also drives write-protect, so the device is protected whenever it is not selected.

Top module: `nand_bus_seq`

## Requirements
- R1: `req_latch[0]=1` makes the access a command cycle, with `nf_cle` high. `req_latch=2'b10` makes it an address cycle, with `nf_ale` high. `2'b00` makes it a data cycle, with both low. If both bits are set, only `nf_cle` rises. `nf_cle` and `nf_ale` are never high together, and each stays high across the whole setup, strobe and hold span of the access.
- R2: A write access has a setup phase of `timing_cfg[29:26]`+1 clocks, then `nf_we_n` low for `timing_cfg[25:20]`+1 clocks, then a hold of `timing_cfg[19:17]`+1 clocks. `req_ack` is high in the last hold clock.
- R3: A read access has a setup of `timing_cfg[16:13]`+1 clocks, then `nf_re_n` low for `timing_cfg[12:7]`+1 clocks, then a hold of `timing_cfg[6:4]`+1 clocks. `nf_dq_in` is sampled in the last strobe clock, and `rd_data` holds that byte when `req_ack` is high.
- R4: Before an access whose direction differs from the previous access, `timing_cfg[3:2]`+1 idle clocks are inserted. No gap is inserted between two accesses of the same direction, or before the first access after reset.
- R5: `timing_cfg` bits 31, 30 and 1:0 have no effect on timing; the bus is always 8 bits wide.
- R6: `dev_ready` equals `nf_rb` (1 = ready) one clock later.
- R7: While `poll_valid` is high, the block leaves the bus quiet for as long as `dev_ready` is 0. Once ready, it issues a command cycle carrying `STATUS_CMD` (default 0x70), then one data read. `poll_done` pulses with the read byte on `rd_data`, and `req_ack` stays low. A pending poll is served before a pending request.
- R8: `chip_sel=0` gives `nf_wp_n=0` and `nf_ce_n=1`. `chip_sel=1` gives `nf_wp_n=1` and `nf_ce_n=0`.
- R9: `req_ack` is high for exactly one clock. During a write, `nf_dq_oe` is high and `nf_dq_out` holds the request byte for the whole setup, strobe and hold span. `nf_dq_oe` is low during reads.
- R10: In reset, `nf_we_n` and `nf_re_n` are high, `nf_cle`, `nf_ale`, `nf_dq_oe`, `req_ack` and `poll_done` are low, and `dev_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timing_cfg | input | 32 | Packed phase timing word |
| req_valid | input | 1 | Host request pending, held until `req_ack` |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_latch | input | 2 | Bit 0 = command cycle, bit 1 = address cycle |
| req_wdata | input | 8 | Write byte |
| req_ack | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte from the last read |
| poll_valid | input | 1 | Wait-and-status request, held until `poll_done` |
| poll_done | output | 1 | One-clock completion pulse of the poll |
| dev_ready | output | 1 | Registered ready/busy status |
| chip_sel | input | 1 | Device selected |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_wp_n | output | 1 | Flash write protect, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Data bus drive value |
| nf_dq_oe | output | 1 | Data bus drive enable |
| nf_dq_in | input | 8 | Data bus input |
| nf_rb | input | 1 | Flash ready/busy, 1 = ready |

## Verification
The bench runs command, address, both-bits and plain data cycles, so that a swapped or merged latch decode shows up as a wrong CLE or ALE count. It runs write-write, write-read, read-read and read-write sequences, which separate a correct turnaround rule from one that always or never inserts the gap. Two different timing words expose any field taken from the wrong bit position. The second word also sets the ignored bits, so any dependence on those bits changes the measured lengths. A poll held behind a busy device checks that nothing moves on the bus before ready, and then that the status command and the read are both correct.

// File: rtl/nand_bus_seq.sv
module nand_bus_seq #(
  parameter logic [7:0] STATUS_CMD = 8'h70
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] timing_cfg,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_latch,
  input  logic [7:0]  req_wdata,
  output logic        req_ack,
  output logic [7:0]  rd_data,
  input  logic        poll_valid,
  output logic        poll_done,
  output logic        dev_ready,
  input  logic        chip_sel,
  output logic        nf_ce_n,
  output logic        nf_wp_n,
  output logic        nf_cle,
  output logic        nf_ale,
  output logic        nf_we_n,
  output logic        nf_re_n,
  output logic [7:0]  nf_dq_out,
  output logic        nf_dq_oe,
  input  logic [7:0]  nf_dq_in,
  input  logic        nf_rb
);

  localparam int CW = 6;

  typedef enum logic [2:0] {S_IDLE, S_POLL, S_TURN, S_SETUP, S_STROBE, S_HOLD} st_t;

  st_t          state;
  logic [CW-1:0] cnt;
  logic         op_write, op_cle, op_ale, in_poll, poll_cmd;
  logic         last_write, have_prev, rb_q;
  logic [7:0]   op_wdata, rdq;

  wire [CW-1:0] w_su = CW'(timing_cfg[29:26]);
  wire [CW-1:0] w_st = CW'(timing_cfg[25:20]);
  wire [CW-1:0] w_ho = CW'(timing_cfg[19:17]);
  wire [CW-1:0] r_su = CW'(timing_cfg[16:13]);
  wire [CW-1:0] r_st = CW'(timing_cfg[12:7]);
  wire [CW-1:0] r_ho = CW'(timing_cfg[6:4]);
  wire [CW-1:0] ta   = CW'(timing_cfg[3:2]);

  logic          launch_w, need_turn;
  logic [CW-1:0] first_len;

  always_comb begin
    case (state)
      S_IDLE:  launch_w = req_write;
      S_HOLD:  launch_w = 1'b0;
      default: launch_w = 1'b1;
    endcase
    need_turn = have_prev && (last_write != launch_w);
    first_len = need_turn ? ta : (launch_w ? w_su : r_su);
  end

  wire last_cnt = (cnt == '0);
  wire active   = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
  wire hold_end = (state == S_HOLD) && last_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      op_write   <= 1'b0;
      op_cle     <= 1'b0;
      op_ale     <= 1'b0;
      op_wdata   <= '0;
      in_poll    <= 1'b0;
      poll_cmd   <= 1'b0;
      last_write <= 1'b0;
      have_prev  <= 1'b0;
      rdq        <= '0;
      rb_q       <= 1'b1;
    end else begin
      rb_q <= nf_rb;
      case (state)
        S_IDLE: begin
          if (poll_valid) begin
            in_poll <= 1'b1;
            state   <= S_POLL;
          end else if (req_valid) begin
            op_write   <= req_write;
            op_cle     <= req_latch[0];
            op_ale     <= req_latch[1] & ~req_latch[0];
            op_wdata   <= req_wdata;
            last_write <= launch_w;
            have_prev  <= 1'b1;
            cnt        <= first_len;
            state      <= need_turn ? S_TURN : S_SETUP;
          end
        end
        S_POLL: begin
          if (rb_q) begin
            op_write   <= 1'b1;
            op_cle     <= 1'b1;
            op_ale     <= 1'b0;
            op_wdata   <= STATUS_CMD;
            poll_cmd   <= 1'b1;
            last_write <= launch_w;
            have_prev  <= 1'b1;
            cnt        <= first_len;
            state      <= need_turn ? S_TURN : S_SETUP;
          end
        end
        S_TURN: begin
          if (last_cnt) begin
            state <= S_SETUP;
            cnt   <= op_write ? w_su : r_su;
          end else cnt <= cnt - 1'b1;
        end
        S_SETUP: begin
          if (last_cnt) begin
            state <= S_STROBE;
            cnt   <= op_write ? w_st : r_st;
          end else cnt <= cnt - 1'b1;
        end
        S_STROBE: begin
          if (last_cnt) begin
            if (!op_write) rdq <= nf_dq_in;
            state <= S_HOLD;
            cnt   <= op_write ? w_ho : r_ho;
          end else cnt <= cnt - 1'b1;
        end
        S_HOLD: begin
          if (last_cnt) begin
            if (poll_cmd) begin
              poll_cmd   <= 1'b0;
              op_write   <= 1'b0;
              op_cle     <= 1'b0;
              last_write <= launch_w;
              cnt        <= first_len;
              state      <= need_turn ? S_TURN : S_SETUP;
            end else begin
              in_poll <= 1'b0;
              state   <= S_IDLE;
            end
          end else cnt <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ack   = hold_end && !in_poll;
  assign poll_done = hold_end && in_poll && !poll_cmd;
  assign rd_data   = rdq;
  assign dev_ready = rb_q;

  assign nf_ce_n   = ~chip_sel;
  assign nf_wp_n   = chip_sel;
  assign nf_cle    = active && op_cle;
  assign nf_ale    = active && op_ale;
  assign nf_we_n   = !((state == S_STROBE) && op_write);
  assign nf_re_n   = !((state == S_STROBE) && !op_write);
  assign nf_dq_oe  = active && op_write;
  assign nf_dq_out = op_wdata;

  a_r1_latch_excl: assert property (@(posedge clk) disable iff (!rst_n) !(nf_cle && nf_ale));
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> !req_ack);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) poll_done |=> !poll_done);
  a_r9_we_drives: assert property (@(posedge clk) disable iff (!rst_n) !nf_we_n |-> nf_dq_oe);
  a_r9_read_float: assert property (@(posedge clk) disable iff (!rst_n) !nf_re_n |-> !nf_dq_oe);
  a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!nf_we_n && $past(!nf_we_n)) |-> $stable(nf_dq_out));
  a_r7_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_POLL) |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale));
  a_r7_no_req_ack: assert property (@(posedge clk) disable iff (!rst_n) in_poll |-> !req_ack);
  a_r5_cfg_known: assert property (@(posedge clk) disable iff (!rst_n) !$isunknown(timing_cfg));

endmodule

// File: tb/nand_bus_seq_tb.sv
module nand_bus_seq_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] timing_cfg = '0;
  logic req_valid = 0, req_write = 0, poll_valid = 0, chip_sel = 0, nf_rb = 1;
  logic [1:0] req_latch = '0;
  logic [7:0] req_wdata = '0, nf_dq_in = '0;
  logic req_ack, poll_done, dev_ready, nf_ce_n, nf_wp_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0] rd_data, nf_dq_out;

  nand_bus_seq u_dut (.clk(clk), .rst_n(rst_n), .timing_cfg(timing_cfg), .req_valid(req_valid),
    .req_write(req_write), .req_latch(req_latch), .req_wdata(req_wdata), .req_ack(req_ack),
    .rd_data(rd_data), .poll_valid(poll_valid), .poll_done(poll_done), .dev_ready(dev_ready),
    .chip_sel(chip_sel), .nf_ce_n(nf_ce_n), .nf_wp_n(nf_wp_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe),
    .nf_dq_in(nf_dq_in), .nf_rb(nf_rb));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_cyc, m_we, m_re, m_cle, m_ale, m_oe, m_bad, m_first_we, m_first_re, m_ack;
  logic [7:0] m_rd;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int wsu, wst, who, rsu, rst, rho, tt, top, sz);
    return {2'(top), 4'(wsu), 6'(wst), 3'(who), 4'(rsu), 6'(rst), 3'(rho), 2'(tt), 2'(sz)};
  endfunction

  task automatic sample(input logic [7:0] d);
    m_cyc++;
    if (!nf_we_n) begin m_we++; if (m_first_we == 0) m_first_we = m_cyc; end
    if (!nf_re_n) begin m_re++; if (m_first_re == 0) m_first_re = m_cyc; end
    if (nf_cle) m_cle++;
    if (nf_ale) m_ale++;
    if (nf_dq_oe) begin m_oe++; if (nf_dq_out != d) m_bad++; end
    if (req_ack) m_ack++;
  endtask

  task automatic clr();
    m_cyc = 0; m_we = 0; m_re = 0; m_cle = 0; m_ale = 0; m_oe = 0; m_bad = 0;
    m_first_we = 0; m_first_re = 0; m_ack = 0;
  endtask

  task automatic run_req(input logic w, input logic [1:0] lat, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_latch = lat; req_wdata = d;
    clr();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      sample(d);
      if (req_ack) break;
    end
    m_rd = rd_data;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk(req_ack == 0, "R9 ack single clock", req_ack, 0);
  endtask

  task automatic t_reset();
    chk(nf_we_n && nf_re_n, "R10 strobes idle high", {nf_we_n, nf_re_n}, 3);
    chk(!nf_cle && !nf_ale && !nf_dq_oe, "R10 latches and drive low", {nf_cle, nf_ale, nf_dq_oe}, 0);
    chk(!req_ack && !poll_done, "R10 no completion", {req_ack, poll_done}, 0);
    chk(dev_ready == 1, "R10 ready after reset", dev_ready, 1);
  endtask

  task automatic t_select();
    chk(nf_wp_n == 0 && nf_ce_n == 1, "R8 deselected protects", {nf_wp_n, nf_ce_n}, 1);
    @(negedge clk); chip_sel = 1; #1;
    chk(nf_wp_n == 1 && nf_ce_n == 0, "R8 selected releases", {nf_wp_n, nf_ce_n}, 2);
  endtask

  task automatic t_cycle_kinds();
    run_req(1, 2'b01, 8'h90);
    chk(m_cyc == 8, "R2 R4 first write length no gap", m_cyc, 8);
    chk(m_first_we == 3, "R2 write setup", m_first_we, 3);
    chk(m_we == 4, "R2 write strobe", m_we, 4);
    chk(m_cle == 8 && m_ale == 0, "R1 command cycle CLE", m_cle, 8);
    chk(m_oe == 8 && m_bad == 0, "R9 write data driven", m_oe, 8);
    run_req(1, 2'b10, 8'h12);
    chk(m_cyc == 8, "R4 write after write no gap", m_cyc, 8);
    chk(m_ale == 8 && m_cle == 0, "R1 address cycle ALE", m_ale, 8);
    run_req(1, 2'b11, 8'h34);
    chk(m_cle == 8 && m_ale == 0, "R1 both bits gives CLE only", m_ale, 0);
  endtask

  task automatic t_reads();
    nf_dq_in = 8'hA5;
    run_req(0, 2'b00, 8'h00);
    chk(m_cyc == 14, "R4 turnaround before read", m_cyc, 14);
    chk(m_first_re == 7, "R3 read setup after gap", m_first_re, 7);
    chk(m_re == 6, "R3 read strobe", m_re, 6);
    chk(m_rd == 8'hA5, "R3 read data", m_rd, 8'hA5);
    chk(m_oe == 0 && m_cle == 0 && m_ale == 0, "R9 R1 read data cycle quiet", m_oe, 0);
    nf_dq_in = 8'h3C;
    run_req(0, 2'b00, 8'h00);
    chk(m_cyc == 10, "R4 read after read no gap", m_cyc, 10);
    chk(m_rd == 8'h3C, "R3 second read data", m_rd, 8'h3C);
    run_req(1, 2'b00, 8'h5A);
    chk(m_cyc == 12, "R4 turnaround before write", m_cyc, 12);
    chk(m_oe == 8 && m_bad == 0, "R9 data write drive", m_bad, 0);
  endtask

  task automatic t_second_cfg();
    timing_cfg = mk(2, 1, 0, 0, 2, 3, 0, 3, 3);
    run_req(1, 2'b00, 8'hC3);
    chk(m_cyc == 6, "R5 R2 write length, ignored bits set", m_cyc, 6);
    chk(m_first_we == 4 && m_we == 2, "R2 second write strobe", m_we, 2);
    nf_dq_in = 8'h81;
    run_req(0, 2'b00, 8'h00);
    chk(m_cyc == 9, "R5 R4 read length with one-clock gap", m_cyc, 9);
    chk(m_first_re == 3 && m_re == 3, "R3 second read strobe", m_re, 3);
    chk(m_rd == 8'h81, "R3 read data second config", m_rd, 8'h81);
  endtask

  task automatic t_ready();
    @(negedge clk); nf_rb = 0; #1;
    chk(dev_ready == 1, "R6 ready not yet updated", dev_ready, 1);
    @(negedge clk);
    chk(dev_ready == 0, "R6 busy one clock later", dev_ready, 0);
  endtask

  task automatic t_poll();
    int busy_act = 0;
    nf_dq_in = 8'hE0;
    @(negedge clk); poll_valid = 1;
    clr();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!nf_we_n || !nf_re_n || nf_cle || nf_ale || poll_done) busy_act++;
    end
    chk(busy_act == 0, "R7 bus quiet while busy", busy_act, 0);
    nf_rb = 1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      sample(STATUS_CMD_TB);
      if (poll_done) break;
    end
    chk(poll_done == 1, "R7 poll completes", poll_done, 1);
    chk(rd_data == 8'hE0, "R7 status byte returned", rd_data, 8'hE0);
    chk(m_cle == 6 && m_we == 2 && m_bad == 0, "R7 status command cycle", m_cle, 6);
    chk(m_re == 3 && m_ack == 0, "R7 read after command, no req ack", m_ack, 0);
    @(posedge clk); #1 poll_valid = 0;
    @(negedge clk);
    chk(poll_done == 0, "R9 poll done single clock", poll_done, 0);
  endtask

  localparam logic [7:0] STATUS_CMD_TB = 8'h70;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    timing_cfg = mk(1, 3, 1, 1, 5, 1, 3, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_select();
    t_cycle_kinds();
    t_reads();
    t_second_cfg();
    t_ready();
    t_poll();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule